// File: doc/BRIEF.md
# Bank-Switching Memory Address Decoder

This block steers every processor access in a 64 KiB space to exactly one target: main RAM, the interpreter ROM, the system ROM, the character ROM, the low or high cartridge ROM, or one of seven I/O windows. Five mode inputs choose the target of each address region. Three of them come from the processor's own port and two from the cartridge slot. The decoder keeps the region map in a register and refreshes it one clock after the mode inputs change. The select itself is combinational from the address and that register, so an access resolves in the cycle it is presented.

Three more pieces of state sit beside the map. The first is a sticky cartridge-only flag. The second is a latch that holds the last value read and feeds color RAM reads. The third is a flag that records a read of the keyboard/joystick port registers. A separate video port turns 14-bit video fetch addresses into a RAM address or a character ROM access, using a 2-bit bank input. The memories and peripherals are outside the block. The integrating design returns the selected target's data on `rd_data_i`.

Top module: `mem_bank_decoder`

## Requirements
- R1: While `rst_ni` is low the region map takes the layout of mode 5'b11111. The cartridge-only flag and the input-read flag clear, and the bus latch is set to 8'hFF.
- R2: An address in 0x0000–0x0FFF always selects RAM, whatever the mode, including cartridge-only mode.
- R3: `mode_i` bits are [4] io_vis, [3] hi_en, [2] lo_en, [1] cart_a_n, [0] cart_b_n. Without a cartridge (bits 1:0 = 11, or 10 whenever cart_a_n=1 and lo_en or hi_en makes a plain mode), these rules apply. 0x1000–0x7FFF and 0xC000–0xCFFF are RAM. 0xA000 holds interpreter ROM only when hi_en, lo_en and cart_a_n are all 1. 0xE000 holds system ROM when hi_en=1, and also for x0000; otherwise it is RAM. 0xD000 is RAM when hi_en=0 and lo_en=0 with cart_a_n=1, and also for 00100. Otherwise 0xD000 is I/O if io_vis=1 and character ROM if io_vis=0. A mode change takes effect one clock edge after it is presented.
- R4: Cartridge maps. 0x8000–0x9FFF selects cartridge low ROM when hi_en=1, lo_en=1 and cart_b_n=0. 0xA000–0xBFFF selects cartridge high ROM when hi_en=1, cart_a_n=0 and cart_b_n=0. The R3 rules cover the rest of the map.
- R5: Mode bits 1:0 = 01 set the cartridge-only flag at the next edge. In that state 0x8000 is cartridge low ROM, 0xD000 is I/O and 0xE000 is cartridge high ROM. 0x1000–0x7FFF and 0xA000–0xCFFF are unmapped. The flag and the map then ignore every mode change until reset.
- R6: When 0xD000 is I/O, address bits 11:8 pick the window. 0–3 selects video registers, 4–7 sound, 8–B color RAM, C I/O chip 0, D I/O chip 1, E expansion 0 and F expansion 1.
- R7: `tgt_sel_o` has at most one bit set. Bit 0 is RAM, 1 interpreter ROM, 2 system ROM, 3 character ROM, 4 cartridge low, 5 cartridge high, 6 video regs, 7 sound, 8 color RAM, 9 I/O chip 0, 10 I/O chip 1, 11 expansion 0 and 12 expansion 1. An unmapped address sets no bit, so a write there reaches nothing, and `rd_data_o` is 8'hFF. Otherwise `rd_data_o` equals `rd_data_i`.
- R8: On each clock edge with `cpu_rd_i` high, `bus_latch_o` captures `rd_data_o`. Otherwise it holds.
- R9: A read of 0xDC00 or 0xDC01 while I/O chip 0 is selected sets `input_read_o` at the next edge. The flag stays set until an edge with `input_clr_i` high, and a clear wins over a set in the same cycle.
- R10: Outside cartridge-only mode, a video address whose bits 13:12 are 01 selects character ROM with `vid_addr_o` = {2'b00, addr}. Any other video address selects RAM at {~vid_bank_i, addr}, so banks 0, 1, 2 and 3 give bases 0xC000, 0x8000, 0x4000 and 0x0000.
- R11: In cartridge-only mode, a video address at 0x3000 or above asserts `vid_zero_o`, meaning the data is 0. A lower address selects RAM at {2'b00, addr}, and the bank input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 5 | Mode lines {io_vis, hi_en, lo_en, cart_a_n, cart_b_n} |
| cpu_addr_i | input | 16 | Processor address |
| cpu_rd_i | input | 1 | Processor read strobe |
| rd_data_i | input | DATA_W | Data returned by the selected target |
| input_clr_i | input | 1 | Clears the input-read flag |
| vid_addr_i | input | 14 | Video fetch address |
| vid_bank_i | input | 2 | Video bank select |
| tgt_sel_o | output | 13 | One-hot target select |
| rd_data_o | output | DATA_W | Read data, 8'hFF when unmapped |
| bus_latch_o | output | DATA_W | Last read value, for color RAM reads |
| cart_only_o | output | 1 | Sticky cartridge-only flag |
| input_read_o | output | 1 | Keyboard/joystick port read flag |
| vid_addr_o | output | 16 | Remapped video address |
| vid_ram_o | output | 1 | Video fetch goes to RAM |
| vid_char_o | output | 1 | Video fetch goes to character ROM |
| vid_zero_o | output | 1 | Video fetch returns zero |

## Verification
The assertions check on every cycle that the select is one-hot or empty, that the low 4 KiB always go to RAM, that an empty select yields 8'hFF, that the latch follows each read, and that the cartridge-only and input-read flags set, hold and clear in the right cycles. Only the bench's scenarios can show that every one of the 32 mode codes produces the right map in every region and I/O window. The same holds for the one-cycle lag of a mode change, for the cartridge-only state ignoring later modes, and for the video remap across all four banks in both normal and cartridge-only state.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  localparam int ADDR_W = 16;
  localparam int MODE_W = 5;
  localparam int VADDR_W = 14;
  localparam int SEL_W = 13;
  localparam int PAGE_W = ADDR_W - 8;

  localparam int S_RAM = 0, S_INTERP = 1, S_SYSROM = 2, S_CHAR = 3, S_CLO = 4, S_CHI = 5;
  localparam int S_VID = 6, S_SND = 7, S_COLOR = 8, S_IO0 = 9, S_IO1 = 10, S_EXP0 = 11, S_EXP1 = 12;

  typedef enum logic [3:0] {
    T_NONE, T_RAM, T_INTERP, T_SYSROM, T_CHAR, T_CLO, T_CHI, T_IO
  } tgt_e;

  // one target per switchable region
  typedef struct packed {
    tgt_e r1;  // 0x1000-0x7fff
    tgt_e r8;  // 0x8000-0x9fff
    tgt_e ra;  // 0xa000-0xbfff
    tgt_e rc;  // 0xc000-0xcfff
    tgt_e rd;  // 0xd000-0xdfff
    tgt_e re;  // 0xe000-0xffff
  } region_map_t;

  localparam region_map_t RESET_MAP = '{r1: T_RAM, r8: T_RAM, ra: T_INTERP,
                                        rc: T_RAM, rd: T_IO, re: T_SYSROM};
endpackage

// File: rtl/mbd_map_table.sv
module mbd_map_table
  import mbd_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output region_map_t       map_o,
  output logic              cart_only_o
);
  logic c, h, l, g, e;
  tgt_e d_sel;

  assign {c, h, l, g, e} = mode_i;
  assign cart_only_o = !g && e;
  assign d_sel = c ? T_IO : T_CHAR;

  // priority order matters: several patterns overlap
  always_comb begin
    map_o = '{r1: T_RAM, r8: T_RAM, ra: T_RAM, rc: T_RAM, rd: T_RAM, re: T_RAM};
    if (!g && e) begin
      map_o = '{r1: T_NONE, r8: T_CLO, ra: T_NONE, rc: T_NONE, rd: T_IO, re: T_CHI};
    end else if (h && l && g && e) begin
      map_o.ra = T_INTERP;
      map_o.rd = d_sel;
      map_o.re = T_SYSROM;
    end else if (!h && l && g) begin
      map_o.rd = d_sel;
    end else if (!h && l && !g && !e) begin
      map_o.rd = c ? T_IO : T_RAM;
    end else if (!h && !l && g) begin
      map_o.rd = T_RAM;
    end else if (h && !l && g) begin
      map_o.rd = d_sel;
      map_o.re = T_SYSROM;
    end else if (!h && !l && !e) begin
      map_o.rd = d_sel;
      map_o.re = T_SYSROM;
    end else if (h && l && g && !e) begin
      map_o.r8 = T_CLO;
      map_o.ra = T_INTERP;
      map_o.rd = d_sel;
      map_o.re = T_SYSROM;
    end else if (h && !l && !g && !e) begin
      map_o.ra = T_CHI;
      map_o.rd = d_sel;
      map_o.re = T_SYSROM;
    end else if (h && l && !g && !e) begin
      map_o.r8 = T_CLO;
      map_o.ra = T_CHI;
      map_o.rd = d_sel;
      map_o.re = T_SYSROM;
    end
  end
endmodule

// File: rtl/mbd_map_reg.sv
module mbd_map_reg
  import mbd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  region_map_t map_d_i,
  input  logic        cart_d_i,
  output region_map_t map_q_o,
  output logic        cart_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      map_q_o  <= RESET_MAP;
      cart_q_o <= 1'b0;
    end else if (!cart_q_o) begin  // frozen once cartridge-only
      map_q_o  <= map_d_i;
      cart_q_o <= cart_d_i;
    end
  end
endmodule

// File: rtl/mbd_cpu_decode.sv
module mbd_cpu_decode
  import mbd_pkg::*;
(
  input  logic [PAGE_W-1:0] page_i,
  input  region_map_t       map_i,
  output logic [SEL_W-1:0]  sel_o
);
  tgt_e t;

  always_comb begin
    case (page_i[7:4])
      4'h0:                          t = T_RAM;
      4'h8, 4'h9:                    t = map_i.r8;
      4'ha, 4'hb:                    t = map_i.ra;
      4'hc:                          t = map_i.rc;
      4'hd:                          t = map_i.rd;
      4'he, 4'hf:                    t = map_i.re;
      default:                       t = map_i.r1;
    endcase
    sel_o = '0;
    case (t)
      T_RAM:    sel_o[S_RAM]    = 1'b1;
      T_INTERP: sel_o[S_INTERP] = 1'b1;
      T_SYSROM: sel_o[S_SYSROM] = 1'b1;
      T_CHAR:   sel_o[S_CHAR]   = 1'b1;
      T_CLO:    sel_o[S_CLO]    = 1'b1;
      T_CHI:    sel_o[S_CHI]    = 1'b1;
      T_IO: begin
        case (page_i[3:0])
          4'h0, 4'h1, 4'h2, 4'h3: sel_o[S_VID]   = 1'b1;
          4'h4, 4'h5, 4'h6, 4'h7: sel_o[S_SND]   = 1'b1;
          4'h8, 4'h9, 4'ha, 4'hb: sel_o[S_COLOR] = 1'b1;
          4'hc:                   sel_o[S_IO0]   = 1'b1;
          4'hd:                   sel_o[S_IO1]   = 1'b1;
          4'he:                   sel_o[S_EXP0]  = 1'b1;
          default:                sel_o[S_EXP1]  = 1'b1;
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mbd_vid_remap.sv
module mbd_vid_remap
  import mbd_pkg::*;
(
  input  logic [VADDR_W-1:0] vid_addr_i,
  input  logic [1:0]         vid_bank_i,
  input  logic               cart_only_i,
  output logic [ADDR_W-1:0]  vid_addr_o,
  output logic               vid_ram_o,
  output logic               vid_char_o,
  output logic               vid_zero_o
);
  logic top_nib;
  logic char_win;

  assign top_nib  = vid_addr_i[13:12] == 2'b11;
  assign char_win = vid_addr_i[13:12] == 2'b01;

  always_comb begin
    vid_ram_o  = 1'b0;
    vid_char_o = 1'b0;
    vid_zero_o = 1'b0;
    vid_addr_o = {2'b00, vid_addr_i};
    if (cart_only_i) begin
      if (top_nib) vid_zero_o = 1'b1;
      else         vid_ram_o  = 1'b1;
    end else if (char_win) begin
      vid_char_o = 1'b1;
    end else begin
      vid_ram_o  = 1'b1;
      vid_addr_o = {~vid_bank_i, vid_addr_i};
    end
  end
endmodule

// File: rtl/mem_bank_decoder.sv
module mem_bank_decoder
  import mbd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic [ADDR_W-1:0]   cpu_addr_i,
  input  logic                cpu_rd_i,
  input  logic [DATA_W-1:0]   rd_data_i,
  input  logic                input_clr_i,
  input  logic [VADDR_W-1:0]  vid_addr_i,
  input  logic [1:0]          vid_bank_i,
  output logic [SEL_W-1:0]    tgt_sel_o,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic [DATA_W-1:0]   bus_latch_o,
  output logic                cart_only_o,
  output logic                input_read_o,
  output logic [ADDR_W-1:0]   vid_addr_o,
  output logic                vid_ram_o,
  output logic                vid_char_o,
  output logic                vid_zero_o
);
  region_map_t map_d, map_q;
  logic        cart_d;
  logic        port_hit;

  mbd_map_table i_table (
    .mode_i      (mode_i),
    .map_o       (map_d),
    .cart_only_o (cart_d)
  );

  mbd_map_reg i_map_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .map_d_i  (map_d),
    .cart_d_i (cart_d),
    .map_q_o  (map_q),
    .cart_q_o (cart_only_o)
  );

  mbd_cpu_decode i_decode (
    .page_i (cpu_addr_i[ADDR_W-1:8]),
    .map_i  (map_q),
    .sel_o  (tgt_sel_o)
  );

  mbd_vid_remap i_vid (
    .vid_addr_i  (vid_addr_i),
    .vid_bank_i  (vid_bank_i),
    .cart_only_i (cart_only_o),
    .vid_addr_o  (vid_addr_o),
    .vid_ram_o   (vid_ram_o),
    .vid_char_o  (vid_char_o),
    .vid_zero_o  (vid_zero_o)
  );

  assign rd_data_o = (tgt_sel_o == '0) ? '1 : rd_data_i;
  // first two registers of I/O chip 0 hold the input ports
  assign port_hit = tgt_sel_o[S_IO0] && (cpu_addr_i[7:0] == 8'h00 || cpu_addr_i[7:0] == 8'h01);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_latch_o  <= '1;
      input_read_o <= 1'b0;
    end else begin
      if (cpu_rd_i) bus_latch_o <= rd_data_o;
      if (input_clr_i)                input_read_o <= 1'b0;
      else if (cpu_rd_i && port_hit)  input_read_o <= 1'b1;
    end
  end
endmodule

// File: rtl/mbd_checker.sv
module mbd_checker
  import mbd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         cart_bits_i,
  input logic [3:0]         addr_hi_i,
  input logic               cpu_rd_i,
  input logic               input_clr_i,
  input logic [SEL_W-1:0]   tgt_sel_o,
  input logic [DATA_W-1:0]  rd_data_o,
  input logic [DATA_W-1:0]  bus_latch_o,
  input logic               cart_only_o,
  input logic               input_read_o,
  input logic [1:0]         vid_top_i,
  input logic               vid_char_o,
  input logic               vid_zero_o
);
  a_r7_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tgt_sel_o));
  a_r2_low_ram: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_hi_i == 4'h0 |-> tgt_sel_o == SEL_W'(1));
  a_r7_unmapped_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_sel_o == '0 |-> rd_data_o == '1);
  a_r5_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cart_bits_i == 2'b01 |=> cart_only_o);
  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cart_only_o |=> cart_only_o);
  a_r8_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rd_i |=> bus_latch_o == $past(rd_data_o));
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    input_read_o && !input_clr_i |=> input_read_o);
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    input_clr_i |=> !input_read_o);
  a_r10_char_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_char_o |-> !cart_only_o && vid_top_i == 2'b00);
  a_r11_zero_cart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vid_zero_o |-> cart_only_o && !vid_char_o);
endmodule

bind mem_bank_decoder mbd_checker #(.DATA_W(DATA_W)) i_mbd_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cart_bits_i  (mode_i[1:0]),
  .addr_hi_i    (cpu_addr_i[15:12]),
  .cpu_rd_i     (cpu_rd_i),
  .input_clr_i  (input_clr_i),
  .tgt_sel_o    (tgt_sel_o),
  .rd_data_o    (rd_data_o),
  .bus_latch_o  (bus_latch_o),
  .cart_only_o  (cart_only_o),
  .input_read_o (input_read_o),
  .vid_top_i    (vid_addr_o[15:14]),
  .vid_char_o   (vid_char_o),
  .vid_zero_o   (vid_zero_o)
);

// File: tb/test_mem_bank_decoder.sv
module test_mem_bank_decoder;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  mode = 5'b11111;
  logic [15:0] addr = '0;
  logic        rd = 1'b0;
  logic [7:0]  rdata = '0;
  logic        clr = 1'b0;
  logic [13:0] vaddr = '0;
  logic [1:0]  vbank = '0;
  logic [12:0] sel;
  logic [7:0]  rdo, latch;
  logic        cart_o, inflag;
  logic [15:0] vout;
  logic        vram, vchar, vzero;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  bit  cart_m = 1'b0;

  always #2 clk = ~clk;

  mem_bank_decoder i_mem_bank_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .cpu_addr_i(addr), .cpu_rd_i(rd),
    .rd_data_i(rdata), .input_clr_i(clr), .vid_addr_i(vaddr), .vid_bank_i(vbank),
    .tgt_sel_o(sel), .rd_data_o(rdo), .bus_latch_o(latch), .cart_only_o(cart_o),
    .input_read_o(inflag), .vid_addr_o(vout), .vid_ram_o(vram), .vid_char_o(vchar),
    .vid_zero_o(vzero)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    cart_m = 1'b0;
  endtask

  // 1 ram, 2 interp, 3 sysrom, 4 char, 5 cart lo, 6 cart hi, 7 io, 0 none
  function automatic logic [12:0] exp_sel(logic [4:0] m, bit cart, logic [15:0] a);
    logic c, h, l, g, e;
    int t, w;
    {c, h, l, g, e} = m;
    if (a < 16'h1000) t = 1;
    else if (cart) begin
      if (a >= 16'he000)      t = 6;
      else if (a >= 16'hd000) t = 7;
      else if (a >= 16'h8000 && a < 16'ha000) t = 5;
      else t = 0;
    end
    else if (a >= 16'he000) t = (h || (!l && !g && !e)) ? 3 : 1;
    else if (a >= 16'hd000) t = ((!h && !l && g) || (!c && !h && l && !g)) ? 1 : (c ? 7 : 4);
    else if (a >= 16'hc000) t = 1;
    else if (a >= 16'ha000) t = (h && l && g) ? 2 : ((h && !g && !e) ? 6 : 1);
    else if (a >= 16'h8000) t = (h && l && !e) ? 5 : 1;
    else t = 1;
    if (t == 0) return '0;
    if (t < 7) return 13'(1) << (t - 1);
    w = int'(a[11:8]);
    if (w < 4) return 13'(1) << 6;
    if (w < 8) return 13'(1) << 7;
    if (w < 12) return 13'(1) << 8;
    return 13'(1) << (w - 12 + 9);
  endfunction

  task automatic vid_sweep(bit cart);
    for (int b = 0; b < 4; b++) begin
      for (int a = 0; a < 64; a++) begin
        logic [13:0] va;
        bit ez, ec;
        logic [15:0] ea;
        va = 14'(a * 256 + a);
        vaddr = va;
        vbank = 2'(b);
        #0.5;
        if (cart) begin
          ez = va >= 14'h3000; ec = 1'b0; ea = {2'b00, va};
          chk(vzero == ez && vram == !ez && vchar == 1'b0, "R11 video flags", {vzero, vram, vchar}, {ez, !ez, 1'b0});
          if (!ez) chk(vout == ea, "R11 video addr", vout, ea);
        end else begin
          ec = va[13:12] == 2'b01;
          ea = ec ? {2'b00, va} : (16'(3 - b) << 14) | 16'(va);
          chk(vchar == ec && vram == !ec && vzero == 1'b0, "R10 video flags", {vzero, vram, vchar}, {1'b0, !ec, ec});
          chk(vout == ea, "R10 video addr", vout, ea);
        end
      end
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset map regardless of mode held at reset
    mode = 5'b00000;
    do_reset();
    addr = 16'ha000; #0.5;
    chk(sel == 13'(1) << 1, "R1 reset map a000", sel, 13'(1) << 1);
    addr = 16'he000; #0.5;
    chk(sel == 13'(1) << 2, "R1 reset map e000", sel, 13'(1) << 2);
    addr = 16'hd000; #0.5;
    chk(sel == 13'(1) << 6, "R1 reset map d000", sel, 13'(1) << 6);
    chk(cart_o == 1'b0 && inflag == 1'b0, "R1 flags", {cart_o, inflag}, 0);
    chk(latch == 8'hff, "R1 latch", latch, 8'hff);

    // R3: one-clock lag on mode change
    mode = 5'b10111;
    addr = 16'ha000; #0.5;
    chk(sel == 13'(1) << 1, "R3 old map before edge", sel, 13'(1) << 1);
    cyc();
    chk(sel == 13'(1), "R3 new map after edge", sel, 13'(1));

    // R2 R3 R4 R5 R6 R7: every mode code against reference
    for (int m = 0; m < 32; m++) begin
      mode = 5'(m);
      do_reset();
      cyc();
      cart_m = (m % 4) == 1;
      chk(cart_o == cart_m, "R5 flag", cart_o, cart_m);
      for (int a = 0; a < 256; a++) begin
        logic [12:0] es;
        logic [7:0]  ed;
        addr = 16'(a * 256 + a);
        rdata = 8'(a) ^ 8'h3c;
        #0.5;
        es = exp_sel(5'(m), cart_m, addr);
        ed = (es == '0) ? 8'hff : rdata;
        chk(sel == es, "R2 R3 R4 R5 R6 select", sel, es);
        chk(rdo == ed, "R7 read data", rdo, ed);
      end
      if (cart_m) begin
        mode = 5'b11111;
        cyc();
        addr = 16'ha000; #0.5;
        chk(sel == '0 && rdo == 8'hff, "R5 sticky ignores mode", sel, 0);
        chk(cart_o == 1'b1, "R5 sticky flag", cart_o, 1);
      end
    end

    // R8: latch
    mode = 5'b11111;
    do_reset();
    cyc();
    addr = 16'h0040; rdata = 8'h5a; rd = 1'b1;
    cyc();
    rd = 1'b0; rdata = 8'h11;
    chk(latch == 8'h5a, "R8 latch capture", latch, 8'h5a);
    cyc();
    chk(latch == 8'h5a, "R8 latch hold", latch, 8'h5a);

    // R9: input flag
    addr = 16'hdc02; rd = 1'b1;
    cyc();
    chk(inflag == 1'b0, "R9 no set on dc02", inflag, 0);
    addr = 16'hdc01;
    cyc();
    rd = 1'b0;
    chk(inflag == 1'b1, "R9 set on dc01", inflag, 1);
    cyc();
    chk(inflag == 1'b1, "R9 holds", inflag, 1);
    clr = 1'b1; addr = 16'hdc00; rd = 1'b1;
    cyc();
    clr = 1'b0; rd = 1'b0;
    chk(inflag == 1'b0, "R9 clear wins", inflag, 0);
    addr = 16'hdc00; rd = 1'b1;
    cyc();
    rd = 1'b0;
    chk(inflag == 1'b1, "R9 set on dc00", inflag, 1);
    clr = 1'b1;
    cyc();
    clr = 1'b0;
    mode = 5'b01111;
    cyc();
    addr = 16'hdc00; rd = 1'b1;
    cyc();
    rd = 1'b0;
    chk(inflag == 1'b0, "R9 no set under char rom", inflag, 0);

    // R10 R11: video remap
    mode = 5'b11111;
    cyc();
    vid_sweep(1'b0);
    mode = 5'b11101;
    cyc();
    vid_sweep(1'b1);

    // R7 R8: unmapped read in cartridge-only mode latches 8'hff
    addr = 16'h2000; rdata = 8'h00; rd = 1'b1;
    cyc();
    rd = 1'b0;
    chk(latch == 8'hff, "R7 R8 unmapped read latch", latch, 8'hff);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule